// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator with Wildcard Fields

This block decides, once per clock-time update, whether the programmed alarm time has been reached. It compares three alarm bytes (seconds, minutes, hours) against the three current-time bytes. It makes the comparison only in the cycle where the update strobe is high. The time counters raise that strobe after they have advanced to the new second. When every field that takes part matches, the block emits a one-cycle alarm pulse. A flag register or an interrupt controller next to it stores and forwards that pulse.

An alarm byte whose two top bits are both set acts as a wildcard for its field. A single register set can therefore request an alarm every second, every minute, every hour or once a day. The fields that are not wildcards are decoded as packed BCD or as plain binary, following a mode input. Hours can be interpreted in 12-hour form, with a PM flag in bit 7, or in 24-hour form. In 12-hour form, both the alarm hour and the current hour are brought to a common 0..23 value before the comparison. While the clock is frozen for setting, no update takes place, and so no alarm is raised.

Top module: `rtc_alarm_match`

## Requirements
- R1: `alarm_pulse` is registered. It goes high for exactly the one cycle that follows a cycle in which `upd_stb` was high, `set_mode` was low and every field matched.
- R2: An alarm byte with bits [7:6] equal to 2'b11 matches any current value of its field. The other fields are still compared.
- R3: When all three alarm bytes are wildcards, every update strobe outside set mode produces a pulse.
- R4: With `bin_mode` = 0, the bytes are packed BCD: value = 10*bits[7:4] + bits[3:0]. For example, in 12-hour mode, alarm hour 0x12 (12 AM) matches current hour 0x00.
- R5: With `bin_mode` = 1, the bytes are plain binary. For example, in 12-hour mode, alarm hour 0x12 (decimal 18) does not match current hour 0x00.
- R6: With `h24_mode` = 0, bit 7 of an hour byte marks PM. The remaining value is reduced modulo 12, and 12 is added when PM is set. So 0x92 (12 PM) does not match 0x12 (12 AM), and 0x81 matches only 0x81. With `h24_mode` = 1, the whole hour byte is the value.
- R7: The hour wildcard test uses the raw byte before any PM masking. Alarm hours 0xC0 to 0xFF are wildcards in both hour modes, while 0xA5 is a normal PM hour.
- R8: While `set_mode` is high, no pulse is produced, even on a strobe with a matching time.
- R9: Without a strobe, no pulse is produced. The alarm bytes sampled at each strobe alone decide that strobe's result, so no earlier setting carries over.
- R10: After reset, `alarm_pulse` is low.
- R11: A mismatch in any single non-wildcard field suppresses the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_stb | input | 1 | One-cycle strobe after the time fields advanced |
| set_mode | input | 1 | Clock frozen for setting; suppresses the alarm |
| bin_mode | input | 1 | 1 = binary bytes, 0 = packed BCD bytes |
| h24_mode | input | 1 | 1 = 24-hour hours, 0 = 12-hour hours with PM in bit 7 |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hr | input | 8 | Alarm hours byte |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hr | input | 8 | Current hours byte |
| alarm_pulse | output | 1 | One-cycle alarm event |

## Verification
The bench builds the block with its defaults: 8-bit fields and the registered output variant (`PIPE_OUT` = 1). With these values, the one-cycle latency of R1 and the whole byte range, including the 0xC0..0xFF wildcard codes, can be observed at the ports. The chosen vectors target the cases where the two decodings or the two hour modes give different answers on the same bytes, such as 0x12 against 0x00. They also cover mixed wildcards and set-mode suppression.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
   localparam int unsigned FIELD_W   = 8;
   localparam int unsigned N_FIELDS  = 3;
   localparam int unsigned HOUR_IDX  = 2;
   localparam logic [1:0]  WILD_CODE = 2'b11;
   localparam logic [7:0]  HALF_DAY  = 8'd12;

   // packed BCD or plain binary byte to an integer value
   function automatic logic [FIELD_W-1:0] byte_value(input logic [FIELD_W-1:0] b,
                                                     input logic bin);
      logic [FIELD_W-1:0] hi, lo;
      hi = {4'd0, b[7:4]};
      lo = {4'd0, b[3:0]};
      return bin ? b : (hi * 8'd10) + lo;
   endfunction
endpackage

// File: rtl/rtc_alm_hour_norm.sv
module rtc_alm_hour_norm
   import rtc_alm_pkg::*;
#(
   parameter int unsigned W = FIELD_W
) (
   input  logic [W-1:0] raw,
   input  logic         bin_mode,
   input  logic         h24_mode,
   output logic [W-1:0] hour_val
);
   logic [W-1:0] body;
   logic [W-1:0] dec;
   logic [W-1:0] mod12;

   always_comb begin
      body     = h24_mode ? raw : {1'b0, raw[W-2:0]};
      dec      = byte_value(body, bin_mode);
      mod12    = dec % HALF_DAY;
      hour_val = h24_mode ? dec : (raw[W-1] ? mod12 + HALF_DAY : mod12);
   end
endmodule

// File: rtl/rtc_alm_field.sv
module rtc_alm_field
   import rtc_alm_pkg::*;
#(
   parameter int unsigned W       = FIELD_W,
   parameter bit          IS_HOUR = 1'b0
) (
   input  logic [W-1:0] raw,
   input  logic         bin_mode,
   input  logic         h24_mode,
   output logic [W-1:0] val
);
   generate
      if (IS_HOUR) begin : g_hour
         rtc_alm_hour_norm #(.W(W)) norm_i (
            .raw      (raw),
            .bin_mode (bin_mode),
            .h24_mode (h24_mode),
            .hour_val (val)
         );
      end else begin : g_plain
         logic unused_mode;
         assign unused_mode = h24_mode;
         assign val = byte_value(raw, bin_mode);
      end
   endgenerate
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
   import rtc_alm_pkg::*;
#(
   parameter int unsigned W        = FIELD_W,
   parameter bit          PIPE_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         upd_stb,
   input  logic         set_mode,
   input  logic         bin_mode,
   input  logic         h24_mode,
   input  logic [W-1:0] alm_sec,
   input  logic [W-1:0] alm_min,
   input  logic [W-1:0] alm_hr,
   input  logic [W-1:0] cur_sec,
   input  logic [W-1:0] cur_min,
   input  logic [W-1:0] cur_hr,
   output logic         alarm_pulse
);
   generate
      if (W != FIELD_W) begin : g_bad_width
         $error("rtc_alarm_match: W must equal the packed byte width");
      end
   endgenerate

   logic [W-1:0]        alm_raw [N_FIELDS];
   logic [W-1:0]        cur_raw [N_FIELDS];
   logic [W-1:0]        alm_val [N_FIELDS];
   logic [W-1:0]        cur_val [N_FIELDS];
   logic [N_FIELDS-1:0] fld_hit;
   logic                fire;

   assign alm_raw[0] = alm_sec;
   assign alm_raw[1] = alm_min;
   assign alm_raw[2] = alm_hr;
   assign cur_raw[0] = cur_sec;
   assign cur_raw[1] = cur_min;
   assign cur_raw[2] = cur_hr;

   generate
      for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
         localparam bit HOUR = (g == HOUR_IDX);
         rtc_alm_field #(.W(W), .IS_HOUR(HOUR)) alm_dec_i (
            .raw (alm_raw[g]), .bin_mode (bin_mode),
            .h24_mode (h24_mode), .val (alm_val[g])
         );
         rtc_alm_field #(.W(W), .IS_HOUR(HOUR)) cur_dec_i (
            .raw (cur_raw[g]), .bin_mode (bin_mode),
            .h24_mode (h24_mode), .val (cur_val[g])
         );
         // wildcard is judged on the raw alarm byte, PM bit included
         assign fld_hit[g] = (alm_raw[g][W-1:W-2] == WILD_CODE) ||
                             (alm_val[g] == cur_val[g]);
      end
   endgenerate

   assign fire = upd_stb && !set_mode && (&fld_hit);

   generate
      if (PIPE_OUT) begin : g_reg
         logic pulse_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= fire;
         end
         assign alarm_pulse = pulse_q;
      end else begin : g_comb
         assign alarm_pulse = fire && rst_n;
      end
   endgenerate
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk #(
   parameter int unsigned W        = 8,
   parameter bit          PIPE_OUT = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         upd_stb,
   input logic         set_mode,
   input logic [W-1:0] alm_sec,
   input logic [W-1:0] alm_min,
   input logic [W-1:0] alm_hr,
   input logic [W-1:0] cur_sec,
   input logic [W-1:0] cur_min,
   input logic [W-1:0] cur_hr,
   input logic         alarm_pulse
);
   generate
      if (PIPE_OUT) begin : g_props
         // R3
         all_wild_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_stb && !set_mode && alm_sec[W-1:W-2] == 2'b11 &&
             alm_min[W-1:W-2] == 2'b11 && alm_hr[W-1:W-2] == 2'b11)
            |=> alarm_pulse);
         // R1
         same_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_stb && !set_mode && alm_sec == cur_sec &&
             alm_min == cur_min && alm_hr == cur_hr) |=> alarm_pulse);
         // R8
         set_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_mode |=> !alarm_pulse);
         // R9
         no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !upd_stb |=> !alarm_pulse);
      end
   endgenerate
endmodule

bind rtc_alarm_match rtc_alarm_match_chk #(.W(W), .PIPE_OUT(PIPE_OUT)) chk_i (
   .clk (clk), .rst_n (rst_n), .upd_stb (upd_stb), .set_mode (set_mode),
   .alm_sec (alm_sec), .alm_min (alm_min), .alm_hr (alm_hr),
   .cur_sec (cur_sec), .cur_min (cur_min), .cur_hr (cur_hr),
   .alarm_pulse (alarm_pulse)
);

// File: tb/rtc_alarm_match_tb_top.sv
module rtc_alarm_match_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       upd_stb = 1'b0, set_mode = 1'b0, bin_mode = 1'b0, h24_mode = 1'b1;
   logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hr = 8'h00;
   logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hr = 8'h00;
   logic       alarm_pulse;
   logic       stb_d = 1'b0;
   int         n_chk = 0, n_bad = 0;
   bit         exp_q[$];
   string      tag_q[$];
   bit         done = 1'b0;

   always #2 clk = ~clk;

   rtc_alarm_match dut_i (
      .clk (clk), .rst_n (rst_n), .upd_stb (upd_stb), .set_mode (set_mode),
      .bin_mode (bin_mode), .h24_mode (h24_mode),
      .alm_sec (alm_sec), .alm_min (alm_min), .alm_hr (alm_hr),
      .cur_sec (cur_sec), .cur_min (cur_min), .cur_hr (cur_hr),
      .alarm_pulse (alarm_pulse)
   );

   always_ff @(posedge clk) stb_d <= upd_stb;

   task automatic check(input bit got, input bit exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: alarm_pulse=%0b expected %0b", tag, got, exp);
      end
   endtask

   // monitor: one pop per strobe, one cycle after it (R1); otherwise pulse must be low (R9)
   always @(negedge clk) begin
      #1;
      if (rst_n && stb_d) begin
         if (exp_q.size() == 0) check(1'b1, 1'b0, "R1 unexpected strobe");
         else check(alarm_pulse, exp_q.pop_front(), tag_q.pop_front());
      end else if (rst_n && alarm_pulse) begin
         check(alarm_pulse, 1'b0, "R9 pulse without strobe");
      end
   end

   task automatic drive(input logic [7:0] as, am, ah, cs, cm, ch,
                        input logic bin, h24, setm, input bit exp, input string tag);
      @(negedge clk);
      alm_sec = as; alm_min = am; alm_hr = ah;
      cur_sec = cs; cur_min = cm; cur_hr = ch;
      bin_mode = bin; h24_mode = h24; set_mode = setm;
      upd_stb = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      upd_stb = 1'b0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 check(alarm_pulse, 1'b0, "R10 reset state");
      rst_n = 1'b1;
      // R3 all wildcards, two different times
      drive(8'hC0, 8'hC0, 8'hC0, 8'h10, 8'h20, 8'h05, 0, 1, 0, 1, "R3 all wild a");
      drive(8'hFF, 8'hD3, 8'hC7, 8'h59, 8'h00, 8'h23, 0, 1, 0, 1, "R3 all wild b");
      // R4 BCD exact, R11 single-field mismatches
      drive(8'h30, 8'h45, 8'h23, 8'h30, 8'h45, 8'h23, 0, 1, 0, 1, "R4 bcd exact");
      drive(8'h30, 8'h45, 8'h23, 8'h31, 8'h45, 8'h23, 0, 1, 0, 0, "R11 sec differs");
      drive(8'h30, 8'h45, 8'h23, 8'h30, 8'h44, 8'h23, 0, 1, 0, 0, "R11 min differs");
      drive(8'h30, 8'h45, 8'h23, 8'h30, 8'h45, 8'h22, 0, 1, 0, 0, "R11 hour differs");
      // R4/R5/R6 decoding and hour form
      drive(8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h00, 0, 0, 0, 1, "R4 12AM bcd vs 0");
      drive(8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h00, 1, 0, 0, 0, "R5 0x12 binary vs 0");
      drive(8'h00, 8'h00, 8'h8C, 8'h00, 8'h00, 8'h80, 1, 0, 0, 1, "R5 binary 12PM forms");
      drive(8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h00, 0, 1, 0, 0, "R6 24h no folding");
      drive(8'h00, 8'h00, 8'h92, 8'h00, 8'h00, 8'h12, 0, 0, 0, 0, "R6 12PM vs 12AM");
      drive(8'h00, 8'h00, 8'h81, 8'h00, 8'h00, 8'h01, 0, 0, 0, 0, "R6 1PM vs 1AM");
      drive(8'h00, 8'h00, 8'h81, 8'h00, 8'h00, 8'h81, 0, 0, 0, 1, "R6 1PM vs 1PM");
      // R7 raw-byte hour wildcard
      drive(8'h05, 8'h07, 8'hE5, 8'h05, 8'h07, 8'h09, 0, 0, 0, 1, "R7 0xE5 wild");
      drive(8'h05, 8'h07, 8'hA5, 8'h05, 8'h07, 8'h09, 0, 0, 0, 0, "R7 0xA5 not wild");
      // R2 partial wildcards
      drive(8'h00, 8'hC5, 8'h08, 8'h00, 8'h33, 8'h08, 0, 1, 0, 1, "R2 min wild");
      drive(8'hC1, 8'h10, 8'h08, 8'h42, 8'h10, 8'h08, 0, 1, 0, 1, "R2 sec wild");
      drive(8'hC1, 8'h10, 8'h08, 8'h42, 8'h11, 8'h08, 0, 1, 0, 0, "R2 others compared");
      // R8 set mode
      drive(8'hC0, 8'hC0, 8'hC0, 8'h01, 8'h02, 8'h03, 0, 1, 1, 0, "R8 set mode");
      // R9 matching inputs held without a strobe
      @(negedge clk);
      alm_sec = 8'h11; alm_min = 8'h22; alm_hr = 8'h03;
      cur_sec = 8'h11; cur_min = 8'h22; cur_hr = 8'h03; set_mode = 1'b0;
      repeat (3) @(negedge clk);
      #1 check(alarm_pulse, 1'b0, "R9 no strobe no pulse");
      // R9 alarm rewrite takes effect at the next strobe
      drive(8'h12, 8'h22, 8'h03, 8'h11, 8'h22, 8'h03, 0, 1, 0, 0, "R9 rewritten mismatch");
      drive(8'h11, 8'h22, 8'h03, 8'h11, 8'h22, 8'h03, 0, 1, 0, 1, "R9 rewritten match");
      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) check(1'b0, 1'b1, "R1 result missing");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule